// File: doc/BRIEF.md
# Dual-Channel Prescaled Interval Timer

This block holds two timer channels that run independently of each other. Every channel divides a shared tick-enable input by a programmable factor of 1 to 256. Each divided tick advances a 16-bit up-counter. When the counter equals the channel's limit on a divided tick, the channel sets a sticky interrupt flag. The counter then either wraps to zero and keeps counting (auto-reload) or holds its value and drops its own enable bit (single-shot). Each channel drives its own interrupt line, gated by a mask bit.

Software sets up the channels through a simple register port with a select, a write strobe, a word address, write data and combinational read data. A write completes on the clock edge at which select is high. The word address splits into a channel number (upper bits) and a register index (lower two bits). Each channel has four words: index 0 control, index 1 divider, index 2 limit, index 3 status. The tick-enable input represents whatever timer clock has been chosen outside the block.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, every word reads as zero (control, divider, limit, status), every channel is disabled and `irq_o` is all zeros.
- R2: A divider value N (word index 1, bits 7:0) advances the counter once per N+1 cycles in which `tick_i` is high while the channel is enabled. N=0 divides by 1 and N=255 divides by 256.
- R3: The counter increments by one on each divided tick and reads back in status bits 31:16.
- R4: Auto-reload (control bit 1 = 0): a divided tick at count == limit sets the flag and returns the count to 0, and counting continues from there.
- R5: Single-shot (control bit 1 = 1): a divided tick at count == limit sets the flag, leaves the count unchanged and clears control bit 0 (enable). After that, ticks have no effect.
- R6: The status flag (status bit 0) stays set until a write of 1 to status bit 0 clears it. Writing 0 to that bit leaves the flag unchanged.
- R7: `irq_o[c]` is high exactly when channel c's flag is set and its mask bit (control bit 2) is 1.
- R8: A control write that takes enable from 0 to 1 clears both the divider phase and the counter before counting begins. Rewriting enable as 1 while it is already 1 clears neither.
- R9: Writes to the divider or limit word while the channel is enabled are ignored. While the channel is disabled they take effect.
- R10: A limit of 0 sets the flag on the first divided tick after enable.
- R11: Activity on one channel leaves the other channel's count, flag and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable, one tick per high cycle |
| psel_i | input | 1 | Register access select |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Word address {channel, index} |
| pwdata_i | input | DATA_W | Write data |
| prdata_o | output | DATA_W | Read data for the addressed word |
| irq_o | output | NUM_CH | Per-channel masked interrupt |

## Verification
The bench reads the count just before and just at a divider boundary. A design that divides by N instead of N+1 shows a count that moves one tick early. It stops a channel with enable cleared part-way through a divider period, then enables it again. A design that keeps the stale divider phase, or that restarts on a redundant enable write, gives a count ahead of the expected value. The bench covers a limit of zero, writes to the limit and divider while a channel is running, and clearing the flag with a 0 as well as a 1. These catch a design that needs a second tick to fire on a zero limit, accepts configuration while the channel runs, or clears the flag on any write. Single-shot runs are followed by extra ticks and by reads of the other channel, which expose a counter that keeps running or activity that reaches the idle channel.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_DIV   = 2'd1,
    REG_LIMIT = 2'd2,
    REG_STAT  = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic mask;
    logic single;
    logic en;
  } ctrl_t;

  localparam int unsigned CTRL_EN_BIT     = 0;
  localparam int unsigned CTRL_SINGLE_BIT = 1;
  localparam int unsigned CTRL_MASK_BIT   = 2;
endpackage

// File: rtl/dtt_prescaler.sv
module dtt_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             ptick_o
);
  logic [PRE_W-1:0] phase_q;
  logic             wrap;

  assign wrap    = (phase_q == div_i);
  assign ptick_o = tick_i & wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (clr_i)  phase_q <= '0;
    else if (tick_i) phase_q <= wrap ? '0 : phase_q + 1'b1;
  end

  AST_PHASE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> phase_q <= div_i); // R2
  AST_CLR_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_q == '0); // R8
endmodule

// File: rtl/dtt_channel.sv
module dtt_channel
  import dtt_pkg::*;
#(
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              ctrl_wr_i,
  input  logic              div_wr_i,
  input  logic              limit_wr_i,
  input  logic              stat_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [PRE_W-1:0]  div_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [PRE_W-1:0] div_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             start, adv, ptick, hit, clr;

  assign start = ctrl_wr_i & wdata_i[CTRL_EN_BIT] & ~ctrl_q.en;
  assign adv   = ctrl_q.en & tick_i & ~ctrl_wr_i;
  assign hit   = ptick & (cnt_q == limit_q);
  assign clr   = stat_wr_i & wdata_i[0];

  dtt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start),
    .tick_i  (adv),
    .div_i   (div_q),
    .ptick_o (ptick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr_i) begin
      ctrl_q.en     <= wdata_i[CTRL_EN_BIT];
      ctrl_q.single <= wdata_i[CTRL_SINGLE_BIT];
      ctrl_q.mask   <= wdata_i[CTRL_MASK_BIT];
    end else if (hit && ctrl_q.single) begin
      ctrl_q.en <= 1'b0;
    end
  end

  // configuration is locked while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      limit_q <= '0;
    end else begin
      if (div_wr_i && !ctrl_q.en)   div_q   <= wdata_i[PRE_W-1:0];
      if (limit_wr_i && !ctrl_q.en) limit_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (ptick) begin
      if (!hit)               cnt_q <= cnt_q + 1'b1;
      else if (!ctrl_q.single) cnt_q <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flag_q <= 1'b0;
    else if (hit)  flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;
  end

  assign ctrl_o  = ctrl_q;
  assign div_o   = div_q;
  assign limit_o = limit_q;
  assign cnt_o   = cnt_q;
  assign flag_o  = flag_q;
  assign irq_o   = flag_q & ctrl_q.mask;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.en |-> cnt_q <= limit_q); // R3
  AST_AUTO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !ctrl_q.single |=> cnt_q == '0 && flag_q); // R4
  AST_SINGLE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && ctrl_q.single |=> !ctrl_q.en && $stable(cnt_q) && flag_q); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr |=> flag_q); // R6
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> cnt_q == '0 && ctrl_q.en); // R8
  AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.en |=> $stable(limit_q) && $stable(div_q)); // R9
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = $clog2(NUM_CH) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              psel_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned CH_W = ADDR_W - 2;

  logic [CH_W-1:0] ch_sel;
  reg_idx_e        idx;
  logic            wr;

  ctrl_t            ctrl  [NUM_CH];
  logic [PRE_W-1:0] div   [NUM_CH];
  logic [CNT_W-1:0] limit [NUM_CH];
  logic [CNT_W-1:0] cnt   [NUM_CH];
  logic [NUM_CH-1:0] flag;

  assign ch_sel = paddr_i[ADDR_W-1:2];
  assign idx    = reg_idx_e'(paddr_i[1:0]);
  assign wr     = psel_i & pwrite_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit_ch;
    assign hit_ch = wr && (ch_sel == CH_W'(c));

    dtt_channel #(.PRE_W(PRE_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .ctrl_wr_i  (hit_ch && idx == REG_CTRL),
      .div_wr_i   (hit_ch && idx == REG_DIV),
      .limit_wr_i (hit_ch && idx == REG_LIMIT),
      .stat_wr_i  (hit_ch && idx == REG_STAT),
      .wdata_i    (pwdata_i),
      .ctrl_o     (ctrl[c]),
      .div_o      (div[c]),
      .limit_o    (limit[c]),
      .cnt_o      (cnt[c]),
      .flag_o     (flag[c]),
      .irq_o      (irq_o[c])
    );

    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> flag[c] && ctrl[c].mask); // R7
  end

  always_comb begin
    prdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel == CH_W'(c)) begin
        unique case (idx)
          REG_CTRL:  prdata_o = DATA_W'({ctrl[c].mask, ctrl[c].single, ctrl[c].en});
          REG_DIV:   prdata_o = DATA_W'(div[c]);
          REG_LIMIT: prdata_o = DATA_W'(limit[c]);
          REG_STAT:  prdata_o = DATA_W'({cnt[c], 15'd0, flag[c]});
          default:   prdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: tb/dual_tick_timer_test.sv
`timescale 1ns/1ps
module dual_tick_timer_test;
  localparam int ADDR_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        psel = 1'b0;
  logic        pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  irq;
  logic        probe = 1'b0;

  int tests = 0;
  int fails = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  dual_tick_timer uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .psel_i   (psel),
    .pwrite_i (pwrite),
    .paddr_i  (paddr),
    .pwdata_i (pwdata),
    .prdata_o (prdata),
    .irq_o    (irq)
  );

  // monitor: compares each probe against the oldest expected item
  always @(negedge clk) begin
    #1;
    if (probe) begin
      item_t it;
      logic [31:0] act;
      it  = exp_q.pop_front();
      act = it.is_irq ? {30'd0, irq} : prdata;
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = ADDR_W'(a); pwdata = d;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
  endtask

  task automatic chk_rd(input int a, input logic [31:0] e, input string r);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = ADDR_W'(a);
    exp_q.push_back('{1'b0, e, r});
    probe = 1'b1;
    @(negedge clk);
    psel = 1'b0; probe = 1'b0;
  endtask

  task automatic chk_irq(input logic [1:0] e, input string r);
    @(negedge clk);
    exp_q.push_back('{1'b1, {30'd0, e}, r});
    probe = 1'b1;
    @(negedge clk);
    probe = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  // ch0: 0..3, ch1: 4..7 (ctrl, div, limit, status)
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    chk_rd(0, 32'h0, "R1 ctrl0");
    chk_rd(1, 32'h0, "R1 div0");
    chk_rd(2, 32'h0, "R1 limit0");
    chk_rd(3, 32'h0, "R1 stat0");
    chk_rd(7, 32'h0, "R1 stat1");
    chk_irq(2'b00, "R1 irq");

    // ch0 auto-reload, divide by 3, limit 5
    wr(1, 32'd2);
    wr(2, 32'd5);
    wr(0, 32'b101);
    ticks(6);
    chk_rd(3, 32'h0002_0000, "R3 count after 6 ticks");
    ticks(2);
    chk_rd(3, 32'h0002_0000, "R2 no advance before boundary");
    ticks(1);
    chk_rd(3, 32'h0003_0000, "R2 advance at boundary");
    ticks(9);
    chk_rd(3, 32'h0000_0001, "R4 wrap at limit");
    chk_irq(2'b01, "R7 irq0 raised");
    ticks(3);
    chk_rd(3, 32'h0001_0001, "R4 continues after wrap");

    // locked config
    wr(2, 32'd100);
    chk_rd(2, 32'd5, "R9 limit locked");
    wr(1, 32'd9);
    chk_rd(1, 32'd2, "R9 div locked");

    // sticky flag
    wr(3, 32'h0);
    chk_rd(3, 32'h0001_0001, "R6 write 0 keeps flag");
    wr(3, 32'h1);
    chk_rd(3, 32'h0001_0000, "R6 write 1 clears flag");
    chk_irq(2'b00, "R6 irq low after clear");

    // mask off, no restart on redundant enable
    wr(0, 32'b001);
    ticks(15);
    chk_rd(3, 32'h0000_0001, "R8 no restart; R4 wrap");
    chk_irq(2'b00, "R7 masked");
    wr(0, 32'b101);
    chk_irq(2'b01, "R7 unmasked");

    // ch1 single-shot, divide by 1, limit 3
    wr(0, 32'b000);
    wr(5, 32'd0);
    wr(6, 32'd3);
    wr(4, 32'b111);
    ticks(4);
    chk_rd(4, 32'b110, "R5 enable cleared");
    chk_rd(7, 32'h0003_0001, "R5 count held, flag set");
    chk_irq(2'b10, "R7 irq1 only");
    ticks(5);
    chk_rd(7, 32'h0003_0001, "R5 stopped");
    chk_rd(3, 32'h0000_0001, "R11 ch0 untouched");

    // restart clears counter and divider phase
    wr(7, 32'h1);
    wr(4, 32'b101);
    chk_rd(7, 32'h0, "R8 counter cleared on enable");
    wr(4, 32'b000);
    wr(5, 32'd3);
    wr(6, 32'd1000);
    chk_rd(6, 32'd1000, "R9 limit accepted when disabled");
    wr(4, 32'b001);
    ticks(2);
    wr(4, 32'b000);
    wr(4, 32'b001);
    ticks(3);
    chk_rd(7, 32'h0, "R8 divider phase cleared");
    ticks(1);
    chk_rd(7, 32'h0001_0000, "R2 divide by 4 after restart");

    // zero limit fires on first divided tick
    wr(3, 32'h1);
    wr(1, 32'd1);
    wr(2, 32'd0);
    wr(0, 32'b111);
    ticks(1);
    chk_rd(3, 32'h0, "R10 not before first divided tick");
    ticks(1);
    chk_rd(3, 32'h1, "R10 flag on first divided tick");
    chk_rd(0, 32'b110, "R10 single-shot stopped");
    chk_irq(2'b01, "R11 irq0 only");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: actual %0d expected 0 pending", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule